// File: doc/BRIEF.md
# RAM Ring-Buffer Transfer Controller

The block moves one data item per peripheral request between a ring buffer held in a synchronous RAM and a peripheral data register. It works in one of two directions. In transmit direction it reads the RAM and writes the peripheral. In receive direction it reads the peripheral and writes the RAM. A read pointer and a write pointer bound the live data. After each transfer the pointer on the moving side advances by one word and wraps inside a configurable address window.

Every transfer runs in two phases: a source read cycle, then a destination write cycle. The request is acknowledged once the write cycle is done. If the moving pointer meets the opposite pointer right after it advances, the block raises an empty flag (transmit) or a full flag (receive). If a request arrives while the pointers are already equal, no bus cycle runs and no pointer moves. The block raises an overread flag (transmit) or an overwrite flag (receive) and acknowledges the request.

A temporary-pointer mode sends transfers through a scratch pointer. That pointer starts as a copy of the moving pointer, and the primary pointer stays untouched. While the enable is low, the block takes its configuration and its pointer start values from its inputs.

Top module: `rbf_xfer_ctrl`

## Requirements
- R1: After reset, all strobes (`ram_re`, `ram_we`, `per_re`, `per_we`), `per_ack`, all four status flags and all three pointer outputs are 0.
- R2: With `cfg_dir`=0 (transmit) and unequal pointers, a request gives one `ram_re` at the moving pointer address. It then gives one `per_we` carrying the word the RAM returned. The moving pointer then advances by one.
- R3: With `cfg_dir`=1 (receive) and unequal pointers, a request gives one `per_re`, then one `ram_we` at the moving pointer address carrying the peripheral word. The moving pointer then advances by one.
- R4: A pointer that advances from `cfg_hi` goes to `cfg_lo`. Any other pointer value goes to the next address.
- R5: In transmit, when the advanced pointer equals the write pointer, the transfer still completes and `st_empty` is set.
- R6: In receive, when the advanced pointer equals the read pointer, the transfer still completes and `st_full` is set.
- R7: In transmit, a request with the pointers already equal gives no strobe, moves no pointer, sets `st_overread` and is acknowledged.
- R8: In receive, a request with the pointers already equal gives no strobe, moves no pointer, sets `st_overwrite` and is acknowledged.
- R9: With `cfg_tmp_en`=1, a scratch pointer starts as a copy of the moving pointer and supplies the transfer address. It alone advances and it is compared with the opposite pointer. The primary pointer keeps its value.
- R10: The flags are sticky until cleared through `st_clr`: bit 0 clears empty, bit 1 clears full, bit 2 clears overread, bit 3 clears overwrite. A clear bit leaves the other flags unchanged.
- R11: While `en`=0, requests get no strobe and no acknowledge. While `en`=0 and the block is idle, the read and write pointers load from `cfg_rd_init` and `cfg_wr_init`, and direction, mode and window are captured.
- R12: `per_ack` is a one-cycle pulse. It comes 4 cycles after an accepted request for a transfer, 1 cycle after for an overread or overwrite. In a transfer it follows the write strobe by exactly one cycle.
- R13: At most one of `ram_re`, `ram_we`, `per_re`, `per_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; configuration loads while low |
| cfg_dir | input | 1 | 0 = RAM to peripheral, 1 = peripheral to RAM |
| cfg_tmp_en | input | 1 | Use the scratch pointer for transfers |
| cfg_lo | input | AW | Lowest address of the ring window |
| cfg_hi | input | AW | Highest address of the ring window |
| cfg_rd_init | input | AW | Read pointer start value |
| cfg_wr_init | input | AW | Write pointer start value |
| st_clr | input | 4 | Per-flag clear mask |
| per_req | input | 1 | Peripheral transfer request, held until acknowledged |
| per_ack | output | 1 | One-cycle acknowledge |
| per_re | output | 1 | Peripheral register read strobe |
| per_rdata | input | DW | Peripheral read data, valid one cycle after `per_re` |
| per_we | output | 1 | Peripheral register write strobe |
| per_wdata | output | DW | Peripheral write data |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after `ram_re` |
| st_empty | output | 1 | Sticky empty flag |
| st_full | output | 1 | Sticky full flag |
| st_overread | output | 1 | Sticky overread flag |
| st_overwrite | output | 1 | Sticky overwrite flag |
| rd_ptr_o | output | AW | Read pointer |
| wr_ptr_o | output | AW | Write pointer |
| tmp_ptr_o | output | AW | Scratch pointer |

## Verification
The assertions assume that `en` changes only while no request is pending. They assume the peripheral holds `per_req` until it sees `per_ack` and drops it in the next cycle. They also assume the RAM and the peripheral return read data exactly one cycle after the read strobe, and that the start pointers lie inside a window with `cfg_lo` not above `cfg_hi`. The stimulus keeps to these terms. Configuration happens only through a task that lowers the enable between requests. Requests come from one task that raises the request and releases it on the acknowledge. The RAM and peripheral models in the bench register their read data on the strobe edge.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  localparam logic DIR_TX = 1'b0;
  localparam logic DIR_RX = 1'b1;

  localparam int NFLG    = 4;
  localparam int FLG_EMP = 0;
  localparam int FLG_FUL = 1;
  localparam int FLG_ORD = 2;
  localparam int FLG_OWR = 3;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_SRC  = 3'd1,
    S_CAP  = 3'd2,
    S_DST  = 3'd3,
    S_ACK  = 3'd4
  } xfer_st_e;
endpackage

// File: rtl/rbf_ptr_unit.sv
module rbf_ptr_unit
  import rbf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic          dir_ld,
  input  logic          dir,
  input  logic          tmp_en,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] rd_init,
  input  logic [AW-1:0] wr_init,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] tmp_ptr,
  output logic [AW-1:0] act_ptr,
  output logic          ptr_eq,
  output logic          meet_next
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] base_ptr;
  logic [AW-1:0] opp_ptr;
  logic [AW-1:0] nxt_ptr;

  always_comb begin
    base_ptr  = (dir == DIR_TX) ? rd_ptr : wr_ptr;
    opp_ptr   = (dir == DIR_TX) ? wr_ptr : rd_ptr;
    act_ptr   = tmp_en ? tmp_ptr : base_ptr;
    nxt_ptr   = (act_ptr == hi) ? lo : act_ptr + ONE;
    ptr_eq    = (act_ptr == opp_ptr);
    meet_next = (nxt_ptr == opp_ptr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      tmp_ptr <= '0;
    end else if (load) begin
      rd_ptr  <= rd_init;
      wr_ptr  <= wr_init;
      tmp_ptr <= (dir_ld == DIR_TX) ? rd_init : wr_init;
    end else if (adv) begin
      if (tmp_en)              tmp_ptr <= nxt_ptr;
      else if (dir == DIR_TX)  rd_ptr  <= nxt_ptr;
      else                     wr_ptr  <= nxt_ptr;
    end
  end
endmodule

// File: rtl/rbf_status.sv
module rbf_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rbf_xfer_fsm.sv
module rbf_xfer_fsm
  import rbf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            dir,
  input  logic            per_req,
  input  logic            ptr_eq,
  input  logic            meet_next,
  input  logic [AW-1:0]   act_ptr,
  input  logic [DW-1:0]   ram_rdata,
  input  logic [DW-1:0]   per_rdata,
  output logic            ram_re,
  output logic            ram_we,
  output logic            per_re,
  output logic            per_we,
  output logic            per_ack,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic [DW-1:0]   per_wdata,
  output logic            adv,
  output logic            idle,
  output logic [NFLG-1:0] flag_set
);
  xfer_st_e state;
  logic     start;
  logic     is_tx;

  always_comb begin
    is_tx = (dir == DIR_TX);
    start = (state == S_IDLE) && en && per_req;
    adv   = (state == S_DST);
    idle  = (state == S_IDLE);
    flag_set          = '0;
    flag_set[FLG_EMP] = adv && meet_next && is_tx;
    flag_set[FLG_FUL] = adv && meet_next && !is_tx;
    flag_set[FLG_ORD] = start && ptr_eq && is_tx;
    flag_set[FLG_OWR] = start && ptr_eq && !is_tx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ram_re    <= 1'b0;
      ram_we    <= 1'b0;
      per_re    <= 1'b0;
      per_we    <= 1'b0;
      per_ack   <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      per_wdata <= '0;
    end else begin
      ram_re  <= 1'b0;
      ram_we  <= 1'b0;
      per_re  <= 1'b0;
      per_we  <= 1'b0;
      per_ack <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (ptr_eq) begin
              per_ack <= 1'b1;
              state   <= S_ACK;
            end else begin
              state <= S_SRC;
              if (is_tx) begin
                ram_re   <= 1'b1;
                ram_addr <= act_ptr;
              end else begin
                per_re <= 1'b1;
              end
            end
          end
        end
        S_SRC: state <= S_CAP;
        S_CAP: begin
          state <= S_DST;
          if (is_tx) begin
            per_we    <= 1'b1;
            per_wdata <= ram_rdata;
          end else begin
            ram_we    <= 1'b1;
            ram_addr  <= act_ptr;
            ram_wdata <= per_rdata;
          end
        end
        S_DST: begin
          per_ack <= 1'b1;
          state   <= S_ACK;
        end
        S_ACK:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbf_xfer_ctrl.sv
module rbf_xfer_ctrl
  import rbf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_dir,
  input  logic          cfg_tmp_en,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic [AW-1:0] cfg_rd_init,
  input  logic [AW-1:0] cfg_wr_init,
  input  logic [3:0]    st_clr,
  input  logic          per_req,
  output logic          per_ack,
  output logic          per_re,
  input  logic [DW-1:0] per_rdata,
  output logic          per_we,
  output logic [DW-1:0] per_wdata,
  output logic          ram_re,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          st_empty,
  output logic          st_full,
  output logic          st_overread,
  output logic          st_overwrite,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] tmp_ptr_o
);
  logic            dir_q;
  logic            tmp_q;
  logic [AW-1:0]   lo_q;
  logic [AW-1:0]   hi_q;
  logic            idle;
  logic            load;
  logic            adv;
  logic            ptr_eq;
  logic            meet_next;
  logic [AW-1:0]   act_ptr;
  logic [NFLG-1:0] flag_set;
  logic [NFLG-1:0] flags;

  assign load = !en && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_TX;
      tmp_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (load) begin
      dir_q <= cfg_dir;
      tmp_q <= cfg_tmp_en;
      lo_q  <= cfg_lo;
      hi_q  <= cfg_hi;
    end
  end

  rbf_ptr_unit #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .adv       (adv),
    .dir_ld    (cfg_dir),
    .dir       (dir_q),
    .tmp_en    (tmp_q),
    .lo        (lo_q),
    .hi        (hi_q),
    .rd_init   (cfg_rd_init),
    .wr_init   (cfg_wr_init),
    .rd_ptr    (rd_ptr_o),
    .wr_ptr    (wr_ptr_o),
    .tmp_ptr   (tmp_ptr_o),
    .act_ptr   (act_ptr),
    .ptr_eq    (ptr_eq),
    .meet_next (meet_next)
  );

  rbf_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .dir       (dir_q),
    .per_req   (per_req),
    .ptr_eq    (ptr_eq),
    .meet_next (meet_next),
    .act_ptr   (act_ptr),
    .ram_rdata (ram_rdata),
    .per_rdata (per_rdata),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .per_re    (per_re),
    .per_we    (per_we),
    .per_ack   (per_ack),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .per_wdata (per_wdata),
    .adv       (adv),
    .idle      (idle),
    .flag_set  (flag_set)
  );

  rbf_status #(.N(NFLG)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (st_clr),
    .flags (flags)
  );

  assign st_empty     = flags[FLG_EMP];
  assign st_full      = flags[FLG_FUL];
  assign st_overread  = flags[FLG_ORD];
  assign st_overwrite = flags[FLG_OWR];
endmodule

// File: rtl/rbf_xfer_ctrl_chk.sv
module rbf_xfer_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [3:0]    st_clr,
  input logic          per_ack,
  input logic          per_re,
  input logic          per_we,
  input logic          ram_re,
  input logic          ram_we,
  input logic          st_empty,
  input logic          st_full,
  input logic          st_overread,
  input logic          st_overwrite,
  input logic [AW-1:0] rd_ptr_o,
  input logic [AW-1:0] wr_ptr_o,
  input logic [AW-1:0] tmp_ptr_o
);
  p_strobe_onehot_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_re, ram_we, per_re, per_we}));

  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> !per_ack);

  p_write_then_ack_r12: assert property (@(posedge clk) disable iff (rst)
    (ram_we || per_we) |=> per_ack);

  p_flag_with_ack_r12: assert property (@(posedge clk) disable iff (rst)
    ($rose(st_empty) || $rose(st_full) || $rose(st_overread) || $rose(st_overwrite))
      |-> per_ack);

  p_rd_moves_after_pwrite_r2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(rd_ptr_o)) |-> $past(per_we));

  p_wr_moves_after_rwrite_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(wr_ptr_o)) |-> $past(ram_we));

  // covers R7 and R8: an acknowledge without a preceding write leaves every pointer alone
  p_no_move_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    (per_ack && !$past(ram_we || per_we)) |->
      ($stable(rd_ptr_o) && $stable(wr_ptr_o) && $stable(tmp_ptr_o)));

  p_start_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(ram_re) || $rose(per_re)) |-> $past(en));

  p_empty_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(st_empty) |-> $past(st_clr[0]));

  p_full_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(st_full) |-> $past(st_clr[1]));
endmodule

bind rbf_xfer_ctrl rbf_xfer_ctrl_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .st_clr       (st_clr),
  .per_ack      (per_ack),
  .per_re       (per_re),
  .per_we       (per_we),
  .ram_re       (ram_re),
  .ram_we       (ram_we),
  .st_empty     (st_empty),
  .st_full      (st_full),
  .st_overread  (st_overread),
  .st_overwrite (st_overwrite),
  .rd_ptr_o     (rd_ptr_o),
  .wr_ptr_o     (wr_ptr_o),
  .tmp_ptr_o    (tmp_ptr_o)
);

// File: tb/sim_rbf_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_rbf_xfer_ctrl;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          cfg_dir = 1'b0;
  logic          cfg_tmp_en = 1'b0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0, cfg_rd_init = '0, cfg_wr_init = '0;
  logic [3:0]    st_clr = '0;
  logic          per_req = 1'b0;
  logic          per_ack, per_re, per_we, ram_re, ram_we;
  logic [DW-1:0] per_rdata = '0, per_wdata, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr, rd_ptr_o, wr_ptr_o, tmp_ptr_o;
  logic          st_empty, st_full, st_overread, st_overwrite;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] per_src = '0;

  int n_cmp = 0, n_bad = 0;
  int rec_rre, rec_pre, rec_we, rec_pwe, ack_at;
  logic [AW-1:0] rec_raddr, rec_waddr;
  logic [DW-1:0] rec_wdata, rec_pdata;

  always #5 clk = ~clk;

  rbf_xfer_ctrl #(.AW(AW), .DW(DW)) u0 (.*);

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (per_re) per_rdata <= per_src;
  end

  typedef struct packed {
    logic [7:0] din;
    logic       wrote;
    logic [7:0] addr;
    logic [7:0] wr_after;
    logic       full;
    logic       ovw;
  } vec_t;

  // receive, window 16..19, rd=18, wr=19
  localparam vec_t RXV [4] = '{
    '{din:8'hA1, wrote:1'b1, addr:8'd19, wr_after:8'd16, full:1'b0, ovw:1'b0},
    '{din:8'hB2, wrote:1'b1, addr:8'd16, wr_after:8'd17, full:1'b0, ovw:1'b0},
    '{din:8'hC3, wrote:1'b1, addr:8'd17, wr_after:8'd18, full:1'b1, ovw:1'b0},
    '{din:8'hD4, wrote:1'b0, addr:8'd0,  wr_after:8'd18, full:1'b1, ovw:1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic configure(input logic d, input logic t, input logic [7:0] lo,
                           input logic [7:0] hi, input logic [7:0] ri, input logic [7:0] wi);
    @(negedge clk);
    en = 1'b0; cfg_dir = d; cfg_tmp_en = t;
    cfg_lo = lo; cfg_hi = hi; cfg_rd_init = ri; cfg_wr_init = wi;
    st_clr = 4'hF;
    @(negedge clk);
    st_clr = 4'h0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_req();
    rec_rre = 0; rec_pre = 0; rec_we = 0; rec_pwe = 0; ack_at = -1;
    per_req = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (ram_re) begin rec_rre++; rec_raddr = ram_addr; end
      if (per_re) rec_pre++;
      if (ram_we) begin rec_we++; rec_waddr = ram_addr; rec_wdata = ram_wdata; end
      if (per_we) begin rec_pwe++; rec_pdata = per_wdata; end
      if (per_ack) begin ack_at = i; break; end
    end
    per_req = 1'b0;
    @(negedge clk);
    chk("R12 ack pulse ends", {31'd0, per_ack}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes", {28'd0, ram_re, ram_we, per_re, per_we}, 32'd0);
    chk("R1 ack", {31'd0, per_ack}, 32'd0);
    chk("R1 flags", {28'd0, st_empty, st_full, st_overread, st_overwrite}, 32'd0);
    chk("R1 ptrs", {8'd0, rd_ptr_o, wr_ptr_o, tmp_ptr_o}, 32'd0);
    rst = 1'b0;

    // receive vectors: R3, R4, R6, R8, R12
    configure(1'b1, 1'b0, 8'd16, 8'd19, 8'd18, 8'd19);
    for (int v = 0; v < 4; v++) begin
      per_src = RXV[v].din;
      do_req();
      chk("R3 ram writes", rec_we, RXV[v].wrote ? 1 : 0);
      chk("R3 per reads", rec_pre, RXV[v].wrote ? 1 : 0);
      chk("R12 ack delay", ack_at, RXV[v].wrote ? 4 : 1);
      if (RXV[v].wrote) begin
        chk("R3 write addr", rec_waddr, RXV[v].addr);
        chk("R3 write data", rec_wdata, RXV[v].din);
      end
      chk("R4 wr pointer", wr_ptr_o, RXV[v].wr_after);
      chk("R6 full flag", st_full, RXV[v].full);
      chk("R8 overwrite flag", st_overwrite, RXV[v].ovw);
      chk("R8 rd pointer", rd_ptr_o, 8'd18);
    end

    // transmit: R2, R4, R5, R7
    mem[34] = 8'h5A; mem[35] = 8'h6B;
    configure(1'b0, 1'b0, 8'd32, 8'd35, 8'd34, 8'd32);
    do_req();
    chk("R2 ram read addr", rec_raddr, 8'd34);
    chk("R2 per data", rec_pdata, 8'h5A);
    chk("R2 rd pointer", rd_ptr_o, 8'd35);
    chk("R5 no empty yet", st_empty, 1'b0);
    do_req();
    chk("R2 per data 2", rec_pdata, 8'h6B);
    chk("R4 rd wraps", rd_ptr_o, 8'd32);
    chk("R5 empty set", st_empty, 1'b1);
    chk("R5 write happened", rec_pwe, 1);
    do_req();
    chk("R7 no strobes", rec_rre + rec_pwe + rec_pre + rec_we, 0);
    chk("R7 overread", st_overread, 1'b1);
    chk("R7 rd unchanged", rd_ptr_o, 8'd32);
    chk("R7 ack delay", ack_at, 1);

    // transmit with scratch pointer: R9
    mem[40] = 8'h11; mem[41] = 8'h22;
    configure(1'b0, 1'b1, 8'd40, 8'd47, 8'd40, 8'd42);
    do_req();
    chk("R9 tmp addr", rec_raddr, 8'd40);
    chk("R9 tmp data", rec_pdata, 8'h11);
    do_req();
    chk("R9 tmp data 2", rec_pdata, 8'h22);
    chk("R9 tmp ptr", tmp_ptr_o, 8'd42);
    chk("R9 rd kept", rd_ptr_o, 8'd40);
    chk("R9 empty on tmp", st_empty, 1'b1);
    do_req();
    chk("R9 overread on tmp", st_overread, 1'b1);

    // receive with scratch pointer: R9
    configure(1'b1, 1'b1, 8'd48, 8'd51, 8'd50, 8'd49);
    per_src = 8'h77;
    do_req();
    chk("R9 rx tmp addr", rec_waddr, 8'd49);
    chk("R9 rx wr kept", wr_ptr_o, 8'd49);
    chk("R9 rx full", st_full, 1'b1);
    chk("R9 rx mem", mem[49], 8'h77);

    // clear mask: R10
    @(negedge clk); st_clr = 4'b0001;
    @(negedge clk); st_clr = 4'b0000;
    chk("R10 full survives other clear", st_full, 1'b1);
    @(negedge clk); st_clr = 4'b0010;
    @(negedge clk); st_clr = 4'b0000;
    chk("R10 full cleared", st_full, 1'b0);

    // disabled: R11
    @(negedge clk);
    en = 1'b0; cfg_rd_init = 8'd5; cfg_wr_init = 8'd9;
    per_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R11 no activity", {27'd0, per_ack, ram_re, ram_we, per_re, per_we}, 32'd0);
    end
    per_req = 1'b0;
    chk("R11 rd loaded", rd_ptr_o, 8'd5);
    chk("R11 wr loaded", wr_ptr_o, 8'd9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule